// File: doc/BRIEF.md
# Dual-Port PCI Command and Status Word

This block holds the 32-bit command/status word of a PCI configuration header. Two agents can read and write it: the PCI configuration port and a local-bus port on the chip side. The word combines three kinds of fields. Sticky error flags are set by one-cycle event pulses from the bus engine and cleared by software writing 1. Enable bits are read/write and drive control outputs to the rest of the controller. Capability fields are constant.

Each port has a write strobe, four byte enables, write data, a read strobe and registered read data. Access rights differ by port for one bit. The 66 MHz capability flag can be changed only from the local bus. The bus engine reports parity errors, aborts and system-error signalling on dedicated pulse inputs. The block turns these into flag updates according to the current enable bits.

Top module: `pcs_cmdstat_reg`

## Requirements
- R1: After reset the word reads 0x02A00000 on both ports, and all six enable outputs are 0.
- R2: Bits 26:25 always read 01 and bit 23 always reads 1. Bits 22, 20, 19:10, 7, 5, 4 and 3 always read 0. A write from either port leaves all of these bits unchanged.
- R3: Bit 31 sets on a detected-parity pulse whatever bit 6 holds. Bit 30 sets on a system-error-sent pulse. Bit 28 sets on a target-abort-received pulse. Bit 27 sets on a target-abort-signalled pulse. Each of these flags is visible from the next clock on.
- R4: Bit 29 sets on a master-abort pulse, but not when the special-cycle qualifier is high in the same cycle.
- R5: Bit 24 sets on a master-parity pulse only while bit 6 is 1.
- R6: Writing 1 to a flag bit (31, 30, 29, 28, 27, 24) from either port clears that flag. Writing 0 to a flag bit leaves it unchanged.
- R7: When a set pulse and a write-1 clear reach the same flag in the same cycle, the flag ends up set.
- R8: Bit 21 resets to 1 and can be written only from the local port. PCI-port writes leave bit 21 unchanged.
- R9: Bits 9, 8, 6, 2, 1 and 0 are read/write from both ports and reset to 0. They drive these outputs, each updated on the clock after the write:
  - bit 9 drives fbb_en
  - bit 8 drives serr_drv_en
  - bit 6 drives parity_resp_en
  - bit 2 drives bus_master_en
  - bit 1 drives mem_dec_en
  - bit 0 drives io_dec_en
- R10: A write changes only the bytes whose byte enable is high. Byte enable bit k covers data bits 8k+7:8k.
- R11: When both ports write the same byte in one cycle, the PCI port sets the read/write bits in that byte. Write-1 clears from both ports combine by OR.
- R12: Read data appears one clock after the read strobe and shows the word as it stood before that clock edge. Without a strobe, the read data holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | PCI port write strobe |
| cfg_be | input | 4 | PCI port byte enables |
| cfg_wdata | input | 32 | PCI port write data |
| cfg_rd_en | input | 1 | PCI port read strobe |
| cfg_rdata | output | 32 | PCI port read data |
| loc_wr_en | input | 1 | Local port write strobe |
| loc_be | input | 4 | Local port byte enables |
| loc_wdata | input | 32 | Local port write data |
| loc_rd_en | input | 1 | Local port read strobe |
| loc_rdata | output | 32 | Local port read data |
| ev_parity_det | input | 1 | Pulse: bus parity error detected |
| ev_serr_sent | input | 1 | Pulse: system error signalled |
| ev_master_abort | input | 1 | Pulse: own master transaction ended in master abort |
| ev_special_cycle | input | 1 | Qualifier: the aborted transaction was a special cycle |
| ev_abort_rcvd | input | 1 | Pulse: own master transaction ended in target abort |
| ev_abort_sent | input | 1 | Pulse: this target ended a transaction with target abort |
| ev_master_perr | input | 1 | Pulse: parity error reported in one of this master's data phases |
| fbb_en | output | 1 | Fast back-to-back enable |
| serr_drv_en | output | 1 | System-error driver enable |
| parity_resp_en | output | 1 | Parity error response enable |
| bus_master_en | output | 1 | Bus master enable |
| mem_dec_en | output | 1 | Memory space decode enable |
| io_dec_en | output | 1 | I/O space decode enable |

## Verification
The assertions treat the event inputs as single-cycle pulses that the bus engine raises in the cycle the event occurs. They treat the special-cycle qualifier as meaningful only alongside a master-abort pulse. Read strobes and writes may coincide freely. The stimulus drives every strobe, event and data value for exactly one clock, away from the active edge. It then returns them to zero, so each event reaches the block as a clean one-cycle pulse. Cases where a clear meets a set, or where both ports write at once, are produced by driving those inputs in the same cycle.

// File: rtl/pcs_pkg.sv
// Package: shared constants and field positions of the command/status word.
// Assumes a 32-bit word with four byte lanes.
package pcs_pkg;
    localparam int REG_W = 32;
    localparam int LANE_W = 8;
    localparam logic [REG_W-1:0] RESET_WORD = 32'h02A0_0000;
    localparam logic [REG_W-1:0] FIXED_ONES = 32'h0280_0000;

    localparam int N_FLAGS = 6;
    localparam int FLAG_POS [N_FLAGS] = '{31, 30, 29, 28, 27, 24};

    localparam int N_RW = 6;
    localparam int RW_POS [N_RW] = '{9, 8, 6, 2, 1, 0};

    localparam int CAP_POS = 21;
    localparam int PER_POS = 6;
endpackage

// File: rtl/pcs_bytemask.sv
// Module: turns a write strobe plus byte enables into a per-bit write mask,
// and the mask ANDed with data (the per-bit "write 1" vector).
// Assumes WORD_W is a multiple of the lane width.
module pcs_bytemask #(
    parameter int WORD_W = pcs_pkg::REG_W
) (
    input  logic                              wr,
    input  logic [WORD_W/pcs_pkg::LANE_W-1:0] be,
    input  logic [WORD_W-1:0]                 data,
    output logic [WORD_W-1:0]                 hit_mask,
    output logic [WORD_W-1:0]                 hit_ones
);
    localparam int LW = pcs_pkg::LANE_W;
    localparam int N_LANES = WORD_W / LW;

    // one replicated strobe per byte lane
    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        assign hit_mask[g*LW +: LW] = {LW{wr & be[g]}};
    end

    // bits written with the value 1
    assign hit_ones = hit_mask & data;
endmodule

// File: rtl/pcs_flag_bank.sv
// Module: bank of sticky error flags. A set pulse wins over a clear in the
// same cycle, so no event is lost. Assumes set/clear are already decoded.
module pcs_flag_bank #(
    parameter int N = pcs_pkg::N_FLAGS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_ev,
    input  logic [N-1:0] clr_req,
    output logic [N-1:0] flags
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        // sticky flag: set has priority over write-1 clear
        always_ff @(posedge clk) begin
            if (!rst_n)          flags[g] <= 1'b0;
            else if (set_ev[g])  flags[g] <= 1'b1;
            else if (clr_req[g]) flags[g] <= 1'b0;
        end
    end
endmodule

// File: rtl/pcs_enable_bank.sv
// Module: read/write enable bits writable from both ports (PCI port wins a
// same-cycle collision per bit) plus the capability bit that only the local
// port may write. Assumes masks already carry byte enables.
module pcs_enable_bank #(
    parameter int WORD_W = pcs_pkg::REG_W,
    parameter int N = pcs_pkg::N_RW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] pci_mask,
    input  logic [WORD_W-1:0] pci_data,
    input  logic [WORD_W-1:0] loc_mask,
    input  logic [WORD_W-1:0] loc_data,
    output logic [N-1:0]      rw_bits,
    output logic              cap_bit
);
    for (genvar g = 0; g < N; g++) begin : g_rw
        localparam int P = pcs_pkg::RW_POS[g];
        // read/write enable with PCI-port priority
        always_ff @(posedge clk) begin
            if (!rst_n)           rw_bits[g] <= 1'b0;
            else if (pci_mask[P]) rw_bits[g] <= pci_data[P];
            else if (loc_mask[P]) rw_bits[g] <= loc_data[P];
        end
    end

    // capability bit: local port only, resets to 1
    always_ff @(posedge clk) begin
        if (!rst_n)                          cap_bit <= 1'b1;
        else if (loc_mask[pcs_pkg::CAP_POS]) cap_bit <= loc_data[pcs_pkg::CAP_POS];
    end
endmodule

// File: rtl/pcs_cmdstat_reg.sv
// Module: dual-port command/status word. Decodes both ports' writes,
// updates sticky flags from bus-engine event pulses, keeps enable bits and
// drives enable outputs; reads are registered with one cycle of latency.
// Assumes event inputs are one-cycle pulses in the clk domain.
module pcs_cmdstat_reg #(
    parameter int WORD_W = pcs_pkg::REG_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr_en,
    input  logic [WORD_W/8-1:0]   cfg_be,
    input  logic [WORD_W-1:0]     cfg_wdata,
    input  logic                  cfg_rd_en,
    output logic [WORD_W-1:0]     cfg_rdata,
    input  logic                  loc_wr_en,
    input  logic [WORD_W/8-1:0]   loc_be,
    input  logic [WORD_W-1:0]     loc_wdata,
    input  logic                  loc_rd_en,
    output logic [WORD_W-1:0]     loc_rdata,
    input  logic                  ev_parity_det,
    input  logic                  ev_serr_sent,
    input  logic                  ev_master_abort,
    input  logic                  ev_special_cycle,
    input  logic                  ev_abort_rcvd,
    input  logic                  ev_abort_sent,
    input  logic                  ev_master_perr,
    output logic                  fbb_en,
    output logic                  serr_drv_en,
    output logic                  parity_resp_en,
    output logic                  bus_master_en,
    output logic                  mem_dec_en,
    output logic                  io_dec_en
);
    import pcs_pkg::*;

    logic [WORD_W-1:0]  pci_mask, pci_ones, loc_mask, loc_ones;
    logic [N_FLAGS-1:0] set_ev, clr_req, flags;
    logic [N_RW-1:0]    rw_bits;
    logic               cap_bit;
    logic [WORD_W-1:0]  stat_word;

    pcs_bytemask #(.WORD_W(WORD_W)) u_pci_mask (
        .wr(cfg_wr_en), .be(cfg_be), .data(cfg_wdata),
        .hit_mask(pci_mask), .hit_ones(pci_ones)
    );

    pcs_bytemask #(.WORD_W(WORD_W)) u_loc_mask (
        .wr(loc_wr_en), .be(loc_be), .data(loc_wdata),
        .hit_mask(loc_mask), .hit_ones(loc_ones)
    );

    // write-1-to-clear requests from both ports are ORed
    for (genvar g = 0; g < N_FLAGS; g++) begin : g_clr
        assign clr_req[g] = pci_ones[FLAG_POS[g]] | loc_ones[FLAG_POS[g]];
    end

    // event qualification, in FLAG_POS order (31,30,29,28,27,24)
    always_comb begin
        set_ev[0] = ev_parity_det;
        set_ev[1] = ev_serr_sent;
        set_ev[2] = ev_master_abort & ~ev_special_cycle;
        set_ev[3] = ev_abort_rcvd;
        set_ev[4] = ev_abort_sent;
        set_ev[5] = ev_master_perr & stat_word[PER_POS];
    end

    pcs_flag_bank #(.N(N_FLAGS)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .set_ev(set_ev), .clr_req(clr_req), .flags(flags)
    );

    pcs_enable_bank #(.WORD_W(WORD_W), .N(N_RW)) u_enables (
        .clk(clk), .rst_n(rst_n),
        .pci_mask(pci_mask), .pci_data(cfg_wdata),
        .loc_mask(loc_mask), .loc_data(loc_wdata),
        .rw_bits(rw_bits), .cap_bit(cap_bit)
    );

    // assemble the visible word from constants, flags and enables
    always_comb begin
        stat_word = FIXED_ONES;
        for (int i = 0; i < N_FLAGS; i++) stat_word[FLAG_POS[i]] = flags[i];
        for (int i = 0; i < N_RW; i++)    stat_word[RW_POS[i]]   = rw_bits[i];
        stat_word[CAP_POS] = cap_bit;
    end

    // PCI-port read register
    always_ff @(posedge clk) begin
        if (!rst_n)         cfg_rdata <= RESET_WORD;
        else if (cfg_rd_en) cfg_rdata <= stat_word;
    end

    // local-port read register
    always_ff @(posedge clk) begin
        if (!rst_n)         loc_rdata <= RESET_WORD;
        else if (loc_rd_en) loc_rdata <= stat_word;
    end

    assign fbb_en         = rw_bits[0];
    assign serr_drv_en    = rw_bits[1];
    assign parity_resp_en = rw_bits[2];
    assign bus_master_en  = rw_bits[3];
    assign mem_dec_en     = rw_bits[4];
    assign io_dec_en      = rw_bits[5];
endmodule

// File: rtl/pcs_cmdstat_chk.sv
// Module: assertion checker for pcs_cmdstat_reg, attached by bind.
// Assumes event inputs are one-cycle pulses.
module pcs_cmdstat_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr_en,
    input logic [3:0]  cfg_be,
    input logic [31:0] cfg_wdata,
    input logic        cfg_rd_en,
    input logic [31:0] cfg_rdata,
    input logic        loc_wr_en,
    input logic [3:0]  loc_be,
    input logic        ev_parity_det,
    input logic        ev_master_abort,
    input logic        ev_special_cycle,
    input logic        ev_abort_sent,
    input logic        ev_master_perr,
    input logic [31:0] stat_word
);
    a_r3_parity_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ev_parity_det |=> stat_word[31]);

    a_r4_special_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_master_abort && ev_special_cycle && !stat_word[29]) |=> !stat_word[29]);

    a_r5_mdpe_needs_per: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_word[24]) |-> $past(ev_master_perr && stat_word[6]));

    a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && cfg_be[3] && cfg_wdata[31] && !ev_parity_det) |=> !stat_word[31]);

    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ev_abort_sent |=> stat_word[27]);

    a_r8_cap_pci_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (!loc_wr_en || !loc_be[2]) |=> $stable(stat_word[21]));

    a_r12_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_en |=> (cfg_rdata == $past(stat_word)));

    a_r12_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd_en |=> $stable(cfg_rdata));
endmodule

bind pcs_cmdstat_reg pcs_cmdstat_chk u_chk (.*);

// File: tb/pcs_cmdstat_reg_test.sv
module pcs_cmdstat_reg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 0, cfg_rd_en = 0, loc_wr_en = 0, loc_rd_en = 0;
    logic [3:0]  cfg_be = 0, loc_be = 0;
    logic [31:0] cfg_wdata = 0, loc_wdata = 0;
    logic [31:0] cfg_rdata, loc_rdata;
    logic        ev_parity_det = 0, ev_serr_sent = 0, ev_master_abort = 0;
    logic        ev_special_cycle = 0, ev_abort_rcvd = 0, ev_abort_sent = 0;
    logic        ev_master_perr = 0;
    logic        fbb_en, serr_drv_en, parity_resp_en, bus_master_en, mem_dec_en, io_dec_en;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pcs_cmdstat_reg uut (.*);

    function automatic logic [5:0] outs();
        return {fbb_en, serr_drv_en, parity_resp_en, bus_master_en, mem_dec_en, io_dec_en};
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    // ev order: [6]parity [5]serr [4]mabort [3]special [2]abort_rcvd [1]abort_sent [0]mperr
    task automatic drive(input logic cw, input logic [3:0] cb, input logic [31:0] cd,
                         input logic lw, input logic [3:0] lb, input logic [31:0] ld,
                         input logic [6:0] ev);
        cfg_wr_en = cw; cfg_be = cb; cfg_wdata = cd;
        loc_wr_en = lw; loc_be = lb; loc_wdata = ld;
        {ev_parity_det, ev_serr_sent, ev_master_abort, ev_special_cycle,
         ev_abort_rcvd, ev_abort_sent, ev_master_perr} = ev;
        @(negedge clk);
        cfg_wr_en = 0; cfg_be = 0; cfg_wdata = 0;
        loc_wr_en = 0; loc_be = 0; loc_wdata = 0;
        {ev_parity_det, ev_serr_sent, ev_master_abort, ev_special_cycle,
         ev_abort_rcvd, ev_abort_sent, ev_master_perr} = '0;
    endtask

    task automatic read_both(input string req, input logic [31:0] exp);
        cfg_rd_en = 1; loc_rd_en = 1;
        @(negedge clk);
        cfg_rd_en = 0; loc_rd_en = 0;
        chk({req, " pci read"}, cfg_rdata, exp);
        chk({req, " local read"}, loc_rdata, exp);
    endtask

    task automatic t_reset();
        chk("R1 reset pci rdata", cfg_rdata, 32'h02A00000);
        read_both("R1 reset word", 32'h02A00000);
        chk("R1 reset outputs", {26'd0, outs()}, 32'd0);
    endtask

    task automatic t_fixed_and_rw();
        drive(1, 4'hF, 32'hFFFFFFFF, 0, 0, 0, 0);
        read_both("R2 R9 pci all ones", 32'h02A00347);
        chk("R9 outputs all set", {26'd0, outs()}, 32'h3F);
        drive(0, 0, 0, 1, 4'hF, 32'h0, 0);
        read_both("R2 R8 local all zero", 32'h02800000);
        chk("R9 outputs cleared", {26'd0, outs()}, 32'd0);
        drive(1, 4'hF, 32'h00200000, 0, 0, 0, 0);
        read_both("R8 pci cannot set cap", 32'h02800000);
        drive(0, 0, 0, 1, 4'h4, 32'h00200000, 0);
        read_both("R8 local sets cap", 32'h02A00000);
        drive(1, 4'hF, 32'h0, 0, 0, 0, 0);
        read_both("R8 pci cannot clear cap", 32'h02A00000);
        drive(0, 0, 0, 1, 4'hF, 32'hFDDFFCB8, 0);
        read_both("R2 local reserved ignored", 32'h02800000);
        drive(0, 0, 0, 1, 4'h4, 32'h00200000, 0);
    endtask

    task automatic t_flags();
        drive(0, 0, 0, 0, 0, 0, 7'b1000000);
        read_both("R3 parity with bit6 clear", 32'h82A00000);
        drive(0, 0, 0, 0, 0, 0, 7'b0100100);
        read_both("R3 serr and abort rcvd", 32'hD2A00000);
        drive(1, 4'h8, 32'h0, 0, 0, 0, 0);
        read_both("R6 write zero keeps flags", 32'hD2A00000);
        drive(1, 4'h4, 32'hFF000000, 0, 0, 0, 0);
        read_both("R10 disabled byte ignored", 32'hD2A00000);
        drive(0, 0, 0, 1, 4'h8, 32'h80000000, 0);
        read_both("R6 local w1c", 32'h52A00000);
        drive(1, 4'h8, 32'h40000000, 1, 4'h8, 32'h10000000, 0);
        read_both("R11 ored w1c", 32'h02A00000);
    endtask

    task automatic t_master_abort();
        drive(0, 0, 0, 0, 0, 0, 7'b0011000);
        read_both("R4 special cycle masked", 32'h02A00000);
        drive(0, 0, 0, 0, 0, 0, 7'b0010000);
        read_both("R4 master abort sets", 32'h22A00000);
        drive(1, 4'h8, 32'h20000000, 0, 0, 0, 0);
        read_both("R6 pci w1c", 32'h02A00000);
    endtask

    task automatic t_mdpe();
        drive(0, 0, 0, 0, 0, 0, 7'b0000001);
        read_both("R5 gated by bit6", 32'h02A00000);
        drive(1, 4'h1, 32'h00000040, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0, 0, 7'b0000001);
        read_both("R5 sets with bit6", 32'h03A00040);
        chk("R9 parity_resp_en", {31'd0, parity_resp_en}, 32'd1);
        drive(1, 4'h9, 32'h01000000, 0, 0, 0, 0);
        read_both("R6 R10 clear flag and bit6", 32'h02A00000);
    endtask

    task automatic t_set_wins();
        drive(1, 4'h8, 32'h08000000, 0, 0, 0, 7'b0000010);
        read_both("R7 set beats clear", 32'h0AA00000);
        drive(0, 0, 0, 1, 4'h8, 32'h08000000, 0);
        read_both("R3 abort sent cleared", 32'h02A00000);
    endtask

    task automatic t_dual_write();
        drive(1, 4'h1, 32'h00000001, 1, 4'h3, 32'h00000306, 0);
        read_both("R11 R10 per-byte merge", 32'h02A00301);
        chk("R9 outputs merged", {26'd0, outs()}, 32'h31);
        drive(1, 4'h2, 32'h0, 1, 4'h2, 32'h00000300, 0);
        read_both("R11 pci priority", 32'h02A00001);
    endtask

    task automatic t_read_latency();
        cfg_rd_en = 1;
        drive(0, 0, 0, 1, 4'h1, 32'h00000002, 0);
        cfg_rd_en = 0;
        chk("R12 read shows pre-edge word", cfg_rdata, 32'h02A00001);
        drive(0, 0, 0, 1, 4'h1, 32'h00000004, 0);
        chk("R12 read data holds", cfg_rdata, 32'h02A00001);
        read_both("R12 later read", 32'h02A00004);
        chk("R9 bus master only", {26'd0, outs()}, 32'h04);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_fixed_and_rw();
        t_flags();
        t_master_abort();
        t_mdpe();
        t_set_wins();
        t_dual_write();
        t_read_latency();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule